// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches a digitised video line, one sample per enabled clock. For each sample it gets a flag that says the signal sits at sync-tip level, and the sample's horizontal position within the line. It adds up sync-low time across the pulses of a line. When that running total passes a programmable limit, it emits a vertical sync strobe. The position in the line at which the strobe fires sets the odd/even field flag.

When vertical sync goes missing, a flywheel keeps the field flag alternating once per nominal field length. After a selectable number of lines with no vertical sync, the block issues a one-cycle request that sends the upstream line-locking loop back to acquisition.

A separate monitor counts whole lines that carry no sync at all. After sixteen such lines it raises a loss-of-input status, which can be gated into a one-cycle interrupt.

Top module: `vsync_field_det`

## Requirements
- R1: After reset, `vsync`, `reacquire`, `los` and `los_irq` are 0 and `field_odd` is 1.
- R2: In each enabled sample with `sync_low` high, the low-time total already gathered in the current line is compared with `vs_thresh`. If the total is equal or larger, `vsync` is high in that same cycle, with no register delay. A broad pulse that starts at position 0 therefore strobes at position `vs_thresh`. The total is gathered over several separate pulses.
- R3: The low-time total clears at position 0 of every line. It also clears when a sync pulse ends after fewer than `EQ_WIDTH` low samples. Normal horizontal sync and short equalising-width pulses therefore never produce `vsync`, whatever the sum of their lengths.
- R4: On the clock after a `vsync` strobe, `field_odd` is 1 if the strobe came at a `line_pos` below `LINE_SAMPLES/2`, and 0 otherwise.
- R5: After a strobe, `vsync` stays suppressed until `REARM_LINES` line starts have passed. A broad-pulse line beginning at the `REARM_LINES`-th line start after the strobe is detected; one beginning a line earlier is not.
- R6: Without vertical sync, `field_odd` inverts at the `FIELD_LINES`-th line start after the last strobe or the last inversion, and keeps doing so.
- R7: `reacquire` pulses for one cycle each time the count of line starts since the last strobe or the last pulse reaches the limit. The limit is set by `tmo_mode`: 0 is `FIXED_LINES`, 1 is `FIELD_LINES`, 2 is `3*FIELD_LINES`, 3 is never.
- R8: `los` rises at the line start that ends the sixteenth consecutive line with no enabled `sync_low` sample. It clears on the clock after the next enabled `sync_low` sample.
- R9: `los_irq` is a one-cycle pulse that coincides with the rise of `los`, and only when `los_irq_en` is 1. It does not repeat while `los` stays high.
- R10: Samples with `smp_en` low change no state. No `vsync` is produced in them, and the low-time total does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample valid / clock enable |
| sync_low | input | 1 | Sample is at sync-tip level |
| line_pos | input | POS_W | Horizontal sample position, 0 at line start |
| vs_thresh | input | CNT_W | Vertical sync detection threshold in samples |
| tmo_mode | input | 2 | Reacquire limit select (R7) |
| los_irq_en | input | 1 | Loss-of-input interrupt enable |
| vsync | output | 1 | Vertical sync strobe (combinational) |
| field_odd | output | 1 | 1 = odd field, 0 = even field |
| reacquire | output | 1 | One-cycle request to restart loop acquisition |
| los | output | 1 | Loss-of-input status |
| los_irq | output | 1 | One-cycle loss-of-input interrupt |

## Verification
Detection is driven with four kinds of line, each telling two behaviours apart:
- Broad pulses starting at line start, which must strobe at exactly the threshold position and give an odd field.
- Broad pulses starting at mid-line, which must strobe late in the line and give an even field.
- Trains of two-sample pulses whose total exceeds the threshold, which must never strobe because short pulses clear the total.
- Trains of three-sample pulses, which must strobe on the eleventh low sample, proving that the total is summed across pulses.

Back-to-back broad-pulse lines probe the re-arm boundary one line either side. Long runs of plain horizontal sync measure the flywheel period and the reacquire period in each mode. Lines with no sync at all probe the sixteen-line loss boundary with the interrupt masked and unmasked. A sample gap with the enable low, in the middle of a broad pulse, must leave the strobe position unchanged.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  typedef enum logic [1:0] {
    TMO_LINES        = 2'd0,
    TMO_ONE_FIELD    = 2'd1,
    TMO_THREE_FIELDS = 2'd2,
    TMO_OFF          = 2'd3
  } tmo_mode_e;
endpackage

// File: rtl/vfd_lowtime.sv
module vfd_lowtime #(
  parameter int CNT_W    = 10,
  parameter int EQ_WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             sync_low,
  input  logic             line_start,
  input  logic             armed,
  input  logic [CNT_W-1:0] thresh,
  output logic             vs_hit
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] EQW  = CNT_W'(EQ_WIDTH);

  logic [CNT_W-1:0] acc_q, acc_d, run_q, run_d, base;
  logic             low_q, low_d, short_end;

  always_comb begin
    base      = line_start ? '0 : acc_q;
    short_end = !sync_low && low_q && (run_q < EQW);
    acc_d     = acc_q;
    run_d     = run_q;
    low_d     = low_q;
    if (smp_en) begin
      low_d = sync_low;
      if (sync_low) run_d = (run_q == CMAX) ? run_q : run_q + 1'b1;
      else          run_d = '0;
      if (short_end)                      acc_d = '0;
      else if (sync_low && base != CMAX)  acc_d = base + 1'b1;
      else                                acc_d = base;
    end
    vs_hit = smp_en && armed && sync_low && (base >= thresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      run_q <= '0;
      low_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      run_q <= run_d;
      low_q <= low_d;
    end
  end
endmodule

// File: rtl/vfd_field_tmr.sv
module vfd_field_tmr
  import vfd_pkg::*;
#(
  parameter int FIELD_LINES = 262,
  parameter int REARM_LINES = 200,
  parameter int FIXED_LINES = 337
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic       vs_hit,
  input  logic       first_half,
  input  logic [1:0] tmo_mode,
  output logic       armed,
  output logic       field_odd,
  output logic       reacq
);
  localparam int M1     = (FIXED_LINES > 3*FIELD_LINES) ? FIXED_LINES : 3*FIELD_LINES;
  localparam int MAXLIM = (M1 > REARM_LINES) ? M1 : REARM_LINES;
  localparam int MW     = $clog2(MAXLIM + 1);
  localparam logic [MW-1:0] FLD_END   = MW'(FIELD_LINES - 1);
  localparam logic [MW-1:0] REARM_END = MW'(REARM_LINES - 1);

  logic [MW-1:0] ln_q, ln_d, rc_q, rc_d, miss_q, miss_d, limit;
  logic          armed_q, armed_d, fld_q, fld_d, rq_q, rq_d;
  tmo_mode_e     mode;

  always_comb begin
    mode = tmo_mode_e'(tmo_mode);
    case (mode)
      TMO_LINES:        limit = MW'(FIXED_LINES);
      TMO_ONE_FIELD:    limit = MW'(FIELD_LINES);
      TMO_THREE_FIELDS: limit = MW'(3*FIELD_LINES);
      default:          limit = MW'(FIXED_LINES);
    endcase
  end

  always_comb begin
    ln_d    = ln_q;
    rc_d    = rc_q;
    miss_d  = miss_q;
    armed_d = armed_q;
    fld_d   = fld_q;
    rq_d    = 1'b0;
    if (vs_hit) begin
      fld_d   = first_half;
      ln_d    = '0;
      rc_d    = '0;
      miss_d  = '0;
      armed_d = 1'b0;
    end else if (line_start) begin
      if (ln_q >= FLD_END) begin
        ln_d  = '0;
        fld_d = !fld_q;
      end else begin
        ln_d = ln_q + 1'b1;
      end
      if (!armed_q) begin
        rc_d = rc_q + 1'b1;
        if (rc_q >= REARM_END) armed_d = 1'b1;
      end
      if (mode != TMO_OFF) begin
        if (miss_q >= limit - 1'b1) begin
          rq_d   = 1'b1;
          miss_d = '0;
        end else begin
          miss_d = miss_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln_q    <= '0;
      rc_q    <= '0;
      miss_q  <= '0;
      armed_q <= 1'b1;
      fld_q   <= 1'b1;
      rq_q    <= 1'b0;
    end else begin
      ln_q    <= ln_d;
      rc_q    <= rc_d;
      miss_q  <= miss_d;
      armed_q <= armed_d;
      fld_q   <= fld_d;
      rq_q    <= rq_d;
    end
  end

  assign armed     = armed_q;
  assign field_odd = fld_q;
  assign reacq     = rq_q;
endmodule

// File: rtl/vfd_los.sv
module vfd_los #(
  parameter int LOS_LINES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic sync_low,
  input  logic line_start,
  input  logic irq_en,
  output logic los,
  output logic los_irq
);
  localparam int LW = $clog2(LOS_LINES + 1);
  localparam logic [LW-1:0] LMAX = LW'(LOS_LINES);
  localparam logic [LW-1:0] LSET = LW'(LOS_LINES - 1);

  logic [LW-1:0] cnt_q, cnt_d;
  logic          saw_q, saw_d, los_q, los_d, irq_q, irq_d, seen;

  always_comb begin
    seen  = smp_en && sync_low;
    saw_d = saw_q;
    cnt_d = cnt_q;
    los_d = los_q;
    if (line_start) begin
      saw_d = sync_low;
      if (saw_q)              cnt_d = '0;
      else if (cnt_q != LMAX) cnt_d = cnt_q + 1'b1;
    end else if (seen) begin
      saw_d = 1'b1;
    end
    if (seen)                                      los_d = 1'b0;
    else if (line_start && !saw_q && cnt_q >= LSET) los_d = 1'b1;
    irq_d = los_d && !los_q && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      saw_q <= 1'b1;
      los_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      saw_q <= saw_d;
      los_q <= los_d;
      irq_q <= irq_d;
    end
  end

  assign los     = los_q;
  assign los_irq = irq_q;
endmodule

// File: rtl/vsync_field_det.sv
module vsync_field_det #(
  parameter int LINE_SAMPLES = 64,
  parameter int CNT_W        = 10,
  parameter int EQ_WIDTH     = 8,
  parameter int FIELD_LINES  = 262,
  parameter int REARM_LINES  = 200,
  parameter int FIXED_LINES  = 337,
  parameter int LOS_LINES    = 16,
  localparam int POS_W       = $clog2(LINE_SAMPLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             sync_low,
  input  logic [POS_W-1:0] line_pos,
  input  logic [CNT_W-1:0] vs_thresh,
  input  logic [1:0]       tmo_mode,
  input  logic             los_irq_en,
  output logic             vsync,
  output logic             field_odd,
  output logic             reacquire,
  output logic             los,
  output logic             los_irq
);
  localparam logic [POS_W-1:0] HALF = POS_W'(LINE_SAMPLES / 2);

  logic line_start, first_half, armed, vs_hit;

  assign line_start = smp_en && (line_pos == '0);
  assign first_half = line_pos < HALF;

  vfd_lowtime #(.CNT_W(CNT_W), .EQ_WIDTH(EQ_WIDTH)) u_lt (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sync_low(sync_low),
    .line_start(line_start), .armed(armed), .thresh(vs_thresh), .vs_hit(vs_hit)
  );

  vfd_field_tmr #(.FIELD_LINES(FIELD_LINES), .REARM_LINES(REARM_LINES),
                  .FIXED_LINES(FIXED_LINES)) u_ft (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .vs_hit(vs_hit),
    .first_half(first_half), .tmo_mode(tmo_mode), .armed(armed),
    .field_odd(field_odd), .reacq(reacquire)
  );

  vfd_los #(.LOS_LINES(LOS_LINES)) u_ls (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sync_low(sync_low),
    .line_start(line_start), .irq_en(los_irq_en), .los(los), .los_irq(los_irq)
  );

  assign vsync = vs_hit;
endmodule

// File: rtl/vfd_chk.sv
module vfd_chk #(
  parameter int POS_W = 6,
  parameter int HALF  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_en,
  input logic             sync_low,
  input logic [POS_W-1:0] line_pos,
  input logic             los_irq_en,
  input logic             vsync,
  input logic             field_odd,
  input logic             reacquire,
  input logic             los,
  input logic             los_irq
);
  // R2
  vs_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> (sync_low && smp_en));

  // R4
  field_from_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (field_odd == $past(int'(line_pos) < HALF)));

  // R5
  vs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> !vsync);

  // R8
  los_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(sync_low && smp_en));

  // R9
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    los_irq |-> ($rose(los) && $past(los_irq_en)));

  // R9
  irq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(los) && $past(los_irq_en)) |-> los_irq);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(field_odd) && $stable(los) && !reacquire && !los_irq));
endmodule

bind vsync_field_det vfd_chk #(.POS_W(POS_W), .HALF(LINE_SAMPLES / 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sync_low(sync_low),
  .line_pos(line_pos), .los_irq_en(los_irq_en), .vsync(vsync),
  .field_odd(field_odd), .reacquire(reacquire), .los(los), .los_irq(los_irq)
);

// File: tb/sim_vsync_field_det.sv
module sim_vsync_field_det;
  localparam int LS = 32;
  localparam int PW = 5;
  localparam int CW = 8;

  localparam logic [31:0] HS    = 32'h0000_000F;
  localparam logic [31:0] NONE  = 32'h0000_0000;
  localparam logic [31:0] ODD   = 32'h1FFF_1FFF;
  localparam logic [31:0] EVEN  = 32'h1FFF_0000;
  localparam logic [31:0] EQ2   = 32'h3333_3333;
  localparam logic [31:0] EQ3   = 32'h7777_7777;

  logic clk, rst_n, smp_en, sync_low, los_irq_en;
  logic [PW-1:0] line_pos;
  logic [CW-1:0] vs_thresh;
  logic [1:0]    tmo_mode;
  logic vsync, field_odd, reacquire, los, los_irq;

  int checks, fails, vs_n, vs_pos, rq_n, irq_n, fld_chg;
  logic fld_prev;
  bit done;

  vsync_field_det #(.LINE_SAMPLES(LS), .CNT_W(CW), .EQ_WIDTH(3), .FIELD_LINES(20),
                    .REARM_LINES(12), .FIXED_LINES(30), .LOS_LINES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sync_low(sync_low),
    .line_pos(line_pos), .vs_thresh(vs_thresh), .tmo_mode(tmo_mode),
    .los_irq_en(los_irq_en), .vsync(vsync), .field_odd(field_odd),
    .reacquire(reacquire), .los(los), .los_irq(los_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    vs_n = 0; vs_pos = -1; rq_n = 0; irq_n = 0; fld_chg = 0;
    fld_prev = field_odd;
  endtask

  task automatic sample_regs();
    if (reacquire) rq_n++;
    if (los_irq)   irq_n++;
    if (field_odd != fld_prev) fld_chg++;
    fld_prev = field_odd;
  endtask

  task automatic run_line(input logic [31:0] m, input int gap_at = -1, input int gap_len = 0);
    for (int p = 0; p < LS; p++) begin
      if (p == gap_at) begin
        for (int g = 0; g < gap_len; g++) begin
          @(negedge clk);
          sample_regs();
          smp_en = 1'b0; sync_low = 1'b1; line_pos = PW'(p);
          #1;
          if (vsync) begin vs_n++; vs_pos = p; end
        end
      end
      @(negedge clk);
      sample_regs();
      smp_en = 1'b1; sync_low = m[p]; line_pos = PW'(p);
      #1;
      if (vsync) begin vs_n++; vs_pos = p; end
    end
  endtask

  task automatic run_lines(input logic [31:0] m, input int n);
    for (int i = 0; i < n; i++) run_line(m);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk("R1 vsync", int'(vsync), 0);
    chk("R1 field_odd", int'(field_odd), 1);
    chk("R1 reacquire", int'(reacquire), 0);
    chk("R1 los", int'(los), 0);
    chk("R1 los_irq", int'(los_irq), 0);
  endtask

  task automatic t_detect();
    clr_mon();
    run_lines(HS, 12);
    chk("R3 hsync only, vsync count", vs_n, 0);
    clr_mon();
    run_line(ODD);
    chk("R2 broad pulse strobe count", vs_n, 1);
    chk("R2 broad pulse strobe position", vs_pos, 10);
    chk("R4 odd field", int'(field_odd), 1);
    run_lines(HS, 12);
    clr_mon();
    run_line(EVEN);
    chk("R4 mid-line strobe position", vs_pos, 26);
    chk("R4 even field", int'(field_odd), 0);
  endtask

  task automatic t_pulse_train();
    run_lines(HS, 12);
    clr_mon();
    run_line(EQ2);
    chk("R3 short pulse train no strobe", vs_n, 0);
    clr_mon();
    run_line(EQ3);
    chk("R2 summed pulses strobe count", vs_n, 1);
    chk("R2 summed pulses strobe position", vs_pos, 13);
    chk("R4 summed pulses odd field", int'(field_odd), 1);
  endtask

  task automatic t_rearm();
    run_lines(HS, 12);
    run_line(ODD);
    clr_mon();
    run_line(ODD);
    chk("R5 next-line broad suppressed", vs_n, 0);
    run_lines(HS, 9);
    clr_mon();
    run_line(ODD);
    chk("R5 eleventh line still suppressed", vs_n, 0);
    clr_mon();
    run_line(ODD);
    chk("R5 twelfth line re-armed", vs_n, 1);
  endtask

  task automatic t_flywheel();
    tmo_mode = 2'd3;
    run_lines(HS, 12);
    run_line(ODD);
    clr_mon();
    run_lines(HS, 19);
    chk("R6 no toggle before period", fld_chg, 0);
    chk("R6 field held odd", int'(field_odd), 1);
    run_line(HS);
    chk("R6 first flywheel toggle", int'(field_odd), 0);
    run_lines(HS, 20);
    chk("R6 keeps toggling", int'(field_odd), 1);
    chk("R6 toggle count", fld_chg, 2);
  endtask

  task automatic t_timeout(input logic [1:0] mode, input int n1, input int exp1,
                           input int n2, input int exp2);
    tmo_mode = mode;
    run_lines(HS, 12);
    run_line(ODD);
    clr_mon();
    run_lines(HS, n1);
    chk($sformatf("R7 mode %0d reacquire count A", mode), rq_n, exp1);
    run_lines(HS, n2);
    chk($sformatf("R7 mode %0d reacquire count B", mode), rq_n, exp2);
  endtask

  task automatic t_los(input logic en, input int exp_irq);
    los_irq_en = en;
    run_line(HS);
    clr_mon();
    run_lines(NONE, 16);
    chk("R8 sixteen empty lines, los still low", int'(los), 0);
    run_line(NONE);
    chk("R8 los set after sixteen empty lines", int'(los), 1);
    run_lines(NONE, 2);
    chk($sformatf("R9 irq count with enable %0d", en), irq_n, exp_irq);
    run_line(HS);
    chk("R8 los cleared by sync", int'(los), 0);
  endtask

  task automatic t_enable_gap();
    tmo_mode = 2'd3;
    run_lines(HS, 12);
    clr_mon();
    run_line(ODD, 5, 40);
    chk("R10 gap strobe count", vs_n, 1);
    chk("R10 gap strobe position", vs_pos, 10);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; smp_en = 1'b1; sync_low = 1'b0; line_pos = '0;
    vs_thresh = CW'(10); tmo_mode = 2'd3; los_irq_en = 1'b0;
    fld_prev = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_detect();
    t_pulse_train();
    t_rearm();
    t_flywheel();
    t_timeout(2'd0, 45, 1, 0, 1);
    t_timeout(2'd1, 45, 2, 0, 2);
    t_timeout(2'd2, 59, 0, 1, 1);
    t_timeout(2'd3, 65, 0, 0, 0);
    tmo_mode = 2'd3;
    t_los(1'b0, 0);
    t_los(1'b1, 1);
    t_enable_gap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule